// File: doc/BRIEF.md
# Six-Digit BCD Event Counter with Eight-Digit Capture Latch

The block counts events as six decimal (BCD) digits in the system clock domain. Its count strobe is the logical OR of two asynchronous inputs. Behind an external two-digit prescaler, those inputs are wired to the weight-4 and weight-8 bits of the prescaler's upper digit. When the block counts pulses directly, one input carries the pulses and the other is tied low. The counter advances by one on every falling edge of the combined strobe and wraps from all nines to all zeros.

A sticky overflow flag sets on the first falling edge of its own asynchronous input. The most significant bit of each of the three upper counter digits is brought out, so one of them can be fed back as that input. An active-low clear input zeroes the counter and the overflow flag. While an active-low capture strobe is held low, an output register copies three things: the six counter digits, two BCD digits supplied from outside as the low-order part of the reading, and the overflow flag. Every asynchronous input passes through a two-stage synchronizer, and all edges are detected after synchronization.

Top module: `dcl_decade_latch`

## Requirements
- R1: Each falling edge of (cnt_a_i OR cnt_b_i) adds exactly one to the counter, from either input. When the two inputs overlap in time, the pair makes a single falling edge of the OR and so counts once.
- R2: A rising edge of the combined strobe, or a strobe held at a steady level, leaves the counter unchanged.
- R3: The counter wraps from all nines to all zeros. Every digit stays in the range 0 to 9.
- R4: While clr_ni is low, the counter and the overflow flag are held at zero. A count edge that arrives while the synchronized clear is active is discarded.
- R5: The overflow flag sets on a falling edge of ovf_i. A rising edge does not set it. Once set, it stays set until clr_ni goes low.
- R6: hi_msb_o[k] is bit 3 of counter digit N_DIG-3+k. With the defaults, bits 0, 1 and 2 are the MSBs of counter digits 3, 4 and 5 (the three most significant).
- R7: While load_ni is low, latch_o is loaded each cycle. latch_o[7:0] takes ext_lo_i, with the lowest external digit in bits 3:0. latch_o[4*(k+2)+3 : 4*(k+2)] takes counter digit k, where digit 0 is the least significant. While load_ni is high, latch_o holds its value.
- R8: ovf_o takes the overflow flag whenever latch_o loads, and holds its value otherwise.
- R9: While rst_ni is low, latch_o, ovf_o and hi_msb_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cnt_a_i | input | 1 | Count strobe A (asynchronous), ORed with B |
| cnt_b_i | input | 1 | Count strobe B (asynchronous), ORed with A |
| ovf_i | input | 1 | Overflow event input (asynchronous), falling edge sets the flag |
| clr_ni | input | 1 | Active-low clear of counter and overflow flag (asynchronous) |
| load_ni | input | 1 | Active-low capture strobe (asynchronous) |
| ext_lo_i | input | 4*N_EXT | External low-order BCD digits |
| hi_msb_o | output | 3 | MSBs of the three upper counter digits |
| latch_o | output | 4*(N_DIG+N_EXT) | Captured BCD reading |
| ovf_o | output | 1 | Captured overflow flag |

## Verification
The bench overlaps the two count inputs so that only one falling edge of their OR occurs. A design that treats the inputs separately would count twice. It holds a strobe high across a capture, so a design that counts on the rising edge shows an early increment. A second, three-digit instance is driven up to 999 and then one step further to exercise the wrap; wrong carry logic would leave a stale digit or a non-BCD code. Count pulses and overflow edges are issued while clear is held, and captures are taken with load released, so a flag that clears on its own, counts that leak through the clear, or a latch that tracks the counter continuously all show up as a miscompare.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int unsigned DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;

  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == BCD_MAX) ? '0 : d + 4'd1;
  endfunction
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int unsigned         WIDTH   = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcl_bcd_counter.sv
module dcl_bcd_counter
  import dcl_pkg::*;
#(
  parameter int unsigned N_DIG = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strobe_i,  // synchronized OR of count inputs
  input  logic                   clr_i,
  output logic [N_DIG*DIG_W-1:0] digits_o
);
  logic             strobe_q;
  logic             fall;
  logic [N_DIG-1:0] carry;
  logic [N_DIG-1:0] nine;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign fall     = strobe_q & ~strobe_i;
  assign carry[0] = fall;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    bcd_t dig_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= '0;
      else if (clr_i)    dig_q <= '0;  // clear wins over a coincident edge
      else if (carry[g]) dig_q <= bcd_step(dig_q);
    end
    assign nine[g] = (dig_q == BCD_MAX);
    if (g < N_DIG - 1) begin : g_carry
      assign carry[g+1] = carry[g] & nine[g];
    end
    assign digits_o[g*DIG_W +: DIG_W] = dig_q;
  end

  // R1
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !clr_i) |=> (digits_o != $past(digits_o)));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && !clr_i) |=> $stable(digits_o));
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !clr_i && (&nine)) |=> (digits_o == '0));
  // R4
  clr_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (digits_o == '0));
endmodule

// File: rtl/dcl_ovf_flag.sv
module dcl_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_s_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ovf_s_i;
  end

  assign fall = prev_q & ~ovf_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (fall)  flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R5
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !fall) |=> !flag_q);
  // R4
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q);
endmodule

// File: rtl/dcl_decade_latch.sv
module dcl_decade_latch
  import dcl_pkg::*;
#(
  parameter int unsigned N_DIG       = 6,
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cnt_a_i,
  input  logic                           cnt_b_i,
  input  logic                           ovf_i,
  input  logic                           clr_ni,
  input  logic                           load_ni,
  input  logic [N_EXT*DIG_W-1:0]         ext_lo_i,
  output logic [2:0]                     hi_msb_o,
  output logic [(N_DIG+N_EXT)*DIG_W-1:0] latch_o,
  output logic                           ovf_o
);
  localparam int unsigned CNT_W = N_DIG * DIG_W;
  localparam int unsigned LAT_W = (N_DIG + N_EXT) * DIG_W;
  localparam int unsigned MSB0  = N_DIG - 3;

  logic [4:0]       async_in;
  logic [4:0]       sync_out;
  logic             strobe_s, ovf_s, clr_s, load_s;
  logic [CNT_W-1:0] cnt_digits;
  logic             flag;
  logic [LAT_W-1:0] latch_q;
  logic             ovf_q;

  assign async_in = {cnt_a_i, cnt_b_i, ovf_i, clr_ni, load_ni};

  // active-low controls reset to their idle level
  dcl_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_in),
    .q_o    (sync_out)
  );

  assign strobe_s = sync_out[4] | sync_out[3];
  assign ovf_s    = sync_out[2];
  assign clr_s    = ~sync_out[1];
  assign load_s   = ~sync_out[0];

  dcl_bcd_counter #(.N_DIG(N_DIG)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_s),
    .clr_i    (clr_s),
    .digits_o (cnt_digits)
  );

  dcl_ovf_flag u_ovf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ovf_s_i (ovf_s),
    .clr_i   (clr_s),
    .flag_o  (flag)
  );

  for (genvar k = 0; k < 3; k++) begin : g_msb
    assign hi_msb_o[k] = cnt_digits[(MSB0 + k)*DIG_W + DIG_W - 1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      ovf_q   <= 1'b0;
    end else if (load_s) begin
      latch_q <= {cnt_digits, ext_lo_i};
      ovf_q   <= flag;
    end
  end

  assign latch_o = latch_q;
  assign ovf_o   = ovf_q;

  // R7
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_s |=> (latch_o[CNT_W + N_EXT*DIG_W - 1 : N_EXT*DIG_W] == $past(cnt_digits)));
  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_s |=> $stable(latch_o));
  // R8
  ovf_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_s |=> (ovf_o == $past(flag)));
  // R8
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_s |=> $stable(ovf_o));
  // R9
  always_comb begin
    if (!rst_ni) begin
      rst_out_chk: assert (latch_o == '0 && !ovf_o && hi_msb_o == '0);
    end
  end
endmodule

// File: tb/dcl_decade_latch_tb.sv
`timescale 1ns/1ps
module dcl_decade_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_a = 1'b0, cnt_b = 1'b0, ovf_in = 1'b0;
  logic        clr_n = 1'b1, load_n = 1'b1;
  logic [7:0]  ext = 8'h00;
  logic [2:0]  msb_big, msb_sml;
  logic [31:0] lat_big;
  logic [19:0] lat_sml;
  logic        ovf_big, ovf_sml;

  int n_chk = 0, n_fail = 0;
  int m6 = 0, m3 = 0;
  bit mflag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dcl_decade_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .ovf_i(ovf_in), .clr_ni(clr_n), .load_ni(load_n), .ext_lo_i(ext),
    .hi_msb_o(msb_big), .latch_o(lat_big), .ovf_o(ovf_big)
  );

  dcl_decade_latch #(.N_DIG(3)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .ovf_i(ovf_in), .clr_ni(clr_n), .load_ni(load_n), .ext_lo_i(ext),
    .hi_msb_o(msb_sml), .latch_o(lat_sml), .ovf_o(ovf_sml)
  );

  function automatic logic [63:0] to_bcd(input int v, input int nd);
    logic [63:0] r = '0;
    int x = v;
    for (int k = 0; k < nd; k++) begin
      r[k*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [2:0] msb_of(input int v, input int first);
    logic [2:0] r;
    int p = 1;
    for (int k = 0; k < first; k++) p = p * 10;
    for (int k = 0; k < 3; k++) begin
      r[k] = ((v / p) % 10) >= 8;
      p = p * 10;
    end
    return r;
  endfunction

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bump();
    m6 = (m6 + 1) % 1000000;
    m3 = (m3 + 1) % 1000;
  endtask

  // src 0: input A, 1: input B, 2: overlapping A then B (one OR edge)
  task automatic pulse(input int src);
    if (src == 0) begin
      cnt_a = 1'b1; w(3); cnt_a = 1'b0; w(4);
    end else if (src == 1) begin
      cnt_b = 1'b1; w(3); cnt_b = 1'b0; w(4);
    end else begin
      cnt_a = 1'b1; w(2); cnt_b = 1'b1; w(2); cnt_a = 1'b0; w(3);
      cnt_b = 1'b0; w(4);
    end
    if (clr_n) bump();
  endtask

  task automatic capture();
    load_n = 1'b0; w(3); load_n = 1'b1; w(4);
  endtask

  task automatic check_all(input string req);
    chk({req, " latch"}, 64'(lat_big), (to_bcd(m6, 6) << 8) | 64'(ext));
    chk({req, " latch3"}, 64'(lat_sml), 64'(((to_bcd(m3, 3) << 8) | 64'(ext)) & 64'hFFFFF));
    chk({req, " ovf"}, 64'(ovf_big), 64'(mflag));
    chk({req, " ovf3"}, 64'(ovf_sml), 64'(mflag));
    chk("R6 msb", 64'(msb_big), 64'(msb_of(m6, 3)));
    chk("R6 msb3", 64'(msb_sml), 64'(msb_of(m3, 0)));
  endtask

  task automatic rand_ext();
    ext = {4'($urandom % 10), 4'($urandom % 10)};
  endtask

  initial begin
    void'($urandom(32'h5eed));
    w(3);
    // R9 reset state
    chk("R9 latch", 64'(lat_big), 64'h0);
    chk("R9 ovf", 64'(ovf_big), 64'h0);
    chk("R9 msb", 64'(msb_big), 64'h0);
    rst_n = 1'b1;
    w(4);

    // R1 each source and overlap
    ext = 8'h42;
    pulse(0); capture(); check_all("R1 src A");
    pulse(1); capture(); check_all("R1 src B");
    pulse(2); capture(); check_all("R1 overlap");

    // R2 rising edge / level does not count
    cnt_b = 1'b1; w(6); capture(); check_all("R2 held high");
    cnt_b = 1'b0; w(4); bump(); capture(); check_all("R2 release");

    // R7 latch holds while load high
    ext = 8'h97;
    pulse(0); pulse(0);
    chk("R7 hold", 64'(lat_big), (to_bcd((m6 + 999998) % 1000000, 6) << 8) | 64'h42);
    capture(); check_all("R7 load");

    // R5 rising edge alone does not set, falling edge does
    ovf_in = 1'b1; w(6); capture(); check_all("R5 rise only");
    ovf_in = 1'b0; w(5); mflag = 1'b1;
    chk("R8 hold before load", 64'(ovf_big), 64'h0);
    capture(); check_all("R5 set");
    ovf_in = 1'b1; w(4); ovf_in = 1'b0; w(4); capture(); check_all("R5 sticky");

    // R4 clear with counts and overflow edges during clear
    clr_n = 1'b0; w(3); m6 = 0; m3 = 0; mflag = 1'b0;
    pulse(0); pulse(2);
    ovf_in = 1'b1; w(3); ovf_in = 1'b0; w(4);
    capture(); check_all("R4 during clear");
    clr_n = 1'b1; w(4); capture(); check_all("R4 after clear");
    // count edge coincident with clear assertion
    cnt_a = 1'b1; w(4);
    cnt_a = 1'b0; clr_n = 1'b0; w(5); clr_n = 1'b1; w(4);
    capture(); check_all("R4 coincident edge");

    // R3 wrap on the three-digit instance, R6 upper MSBs
    for (int i = 0; i < 999; i++) pulse(i % 2);
    capture(); check_all("R3 at 999");
    pulse(1); capture(); check_all("R3 wrap");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int np = $urandom % 30;
      for (int p = 0; p < np; p++) pulse($urandom % 3);
      if (($urandom % 6) == 0) begin
        ovf_in = 1'b1; w(3); ovf_in = 1'b0; w(4); mflag = 1'b1;
      end
      if (($urandom % 8) == 0) begin
        clr_n = 1'b0; w(5); clr_n = 1'b1; w(4);
        m6 = 0; m3 = 0; mflag = 1'b0;
      end
      rand_ext();
      capture();
      check_all("R7 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule